// File: doc/BRIEF.md
# Transmit Sample FIFO with Level and Empty Interrupts

This block sits between a register-mapped control port and an audio serializer. Software writes 32-bit channel samples one at a time to a data port, always left then right, so each stereo frame occupies two entries. Each accepted word is stored together with a channel tag. The serializer pulls words through a valid/ready stream in the order they were written.

Two conditions are watched on the live occupancy. The first is occupancy below a programmable trigger; software uses it to know when to refill. The second is an empty FIFO, which means the serializer is starving. Each condition has a sticky status bit with its own interrupt enable, and the enabled bits are merged into one registered interrupt line. Clearing a status bit only hides it for one cycle, so a condition that still holds shows up again at once. A write to a full FIFO is dropped and recorded in a separate sticky bit that never raises the interrupt.

Top module: `audio_tx_fifo`

## Requirements
- R1: Words leave on `m_data` in the order they were accepted. `m_valid` is high exactly when the FIFO holds at least one word, and a word is removed on each cycle with `m_valid` and `m_ready` both high.
- R2: Each accepted data-port write carries a channel tag on `m_right`. The tag is 0 (left) for the first accepted word after reset and alternates on every accepted write.
- R3: Occupancy is readable in status bits [8 +: CW], where CW = clog2(DEPTH+1). A push and a pop in the same cycle leave it unchanged.
- R4: A write to the data port (address 0) while occupancy equals DEPTH is dropped, and it sets the overflow bit (status bit 2). That bit stays set until a one is written to status bit 2, and it never affects `irq`. An overflow in the same cycle as its clear keeps the bit set.
- R5: The level bit (status bit 0) is set in the cycle after one in which occupancy was below the trigger register (address 3, CW bits).
- R6: The underrun bit (status bit 1) is set in the cycle after one in which occupancy was zero.
- R7: The level and underrun bits are sticky: once set, they stay set after their condition goes away, until they are cleared.
- R8: Writing the status register (address 1) with a one in bit 0 or bit 1 clears that bit at the next edge. If its condition still holds, the bit reads as set again one cycle later.
- R9: `irq` is a register that equals the OR of (level AND enable bit 0) and (underrun AND enable bit 1). The enable register is at address 2.
- R10: The trigger and enable registers read back what was written. After reset they read DEPTH/2 and 0. A read of address 0 returns zero.
- R11: After reset the FIFO is empty, all status bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 enable, 3 trigger |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the selected register |
| m_valid | output | 1 | Head word available to the serializer |
| m_ready | input | 1 | Serializer accepts the head word |
| m_data | output | DW | Head sample word |
| m_right | output | 1 | Channel tag of the head word (1 = right) |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A software push and a serializer pop can land in the same cycle. So can a status clear and the re-evaluation of the condition it clears. The random phase drives data-port writes and pops together, with random ready rates and trigger values. It also fires clears while the FIFO sits empty or below the trigger. Directed steps push into a full FIFO while it is popping, and clear bits whose condition holds. Occupancy, the status bits and the interrupt are compared in every cycle against a bench model built from the requirements, which checks that counts stay balanced and that a cleared bit returns after exactly one cycle.

// File: rtl/atf_pkg.sv
package atf_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_TRIG = 2'd3
    } reg_sel_e;

    localparam int BIT_LVL = 0;
    localparam int BIT_UND = 1;
    localparam int BIT_OVF = 2;
    localparam int OCC_LSB = 8;
endpackage

// File: rtl/atf_store.sv
module atf_store #(
    parameter int EW    = 33,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_word,
    input  logic          pop,
    output logic [EW-1:0] head_word,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          ptr_d, ptr_q;
    logic          do_push, do_pop;
    logic [EW-1:0] mem [DEPTH];

    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);
    assign occ   = ptr_q.cnt;

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        if (do_push) ptr_d.wp = ptr_q.wp + 1'b1;
        if (do_pop)  ptr_d.rp = ptr_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp] <= push_word;
    end

    assign head_word = mem[ptr_q.rp];
endmodule

// File: rtl/atf_status.sv
module atf_status #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] trig,
    input  logic [1:0]    ien_nxt,
    input  logic [2:0]    clr,
    input  logic          ovf_evt,
    output logic [2:0]    st,
    output logic          irq
);
    typedef struct packed {
        logic lvl;
        logic und;
        logic ovf;
        logic irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = clr[0] ? 1'b0 : (st_q.lvl | (occ < trig));
        st_d.und = clr[1] ? 1'b0 : (st_q.und | (occ == '0));
        st_d.ovf = ovf_evt | (st_q.ovf & ~clr[2]);
        st_d.irq = (st_d.lvl & ien_nxt[0]) | (st_d.und & ien_nxt[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st  = {st_q.ovf, st_q.und, st_q.lvl};
    assign irq = st_q.irq;
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int EW   = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [DW-1:0] m_data,
    output logic          m_right,
    output logic          irq
);
    typedef struct packed {
        logic [CW-1:0] trig;
        logic [1:0]    ien;
        logic          phase;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    reg_sel_e      sel;
    logic          data_wr, push_ok, ovf_evt, pop;
    logic [2:0]    clr;
    logic [EW-1:0] head_word;
    logic [CW-1:0] occ;
    logic          full, empty;
    logic [2:0]    st;
    logic [1:0]    ien_q;

    assign sel     = reg_sel_e'(reg_addr);
    assign data_wr = reg_wr && (sel == SEL_DATA);
    assign push_ok = data_wr && !full;
    assign ovf_evt = data_wr && full;
    assign pop     = m_valid && m_ready;
    assign clr     = (reg_wr && (sel == SEL_STAT)) ? reg_wdata[2:0] : 3'b000;
    assign ien_q   = ctl_q.ien;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && sel == SEL_TRIG) ctl_d.trig = reg_wdata[CW-1:0];
        if (reg_wr && sel == SEL_IEN)  ctl_d.ien  = reg_wdata[1:0];
        if (push_ok)                   ctl_d.phase = ~ctl_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.trig  <= CW'(DEPTH / 2);
            ctl_q.ien   <= 2'b00;
            ctl_q.phase <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    atf_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .push_word ({ctl_q.phase, reg_wdata}),
        .pop       (pop),
        .head_word (head_word),
        .occ       (occ),
        .full      (full),
        .empty     (empty)
    );

    atf_status #(.CW(CW)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ     (occ),
        .trig    (ctl_q.trig),
        .ien_nxt (ctl_d.ien),
        .clr     (clr),
        .ovf_evt (ovf_evt),
        .st      (st),
        .irq     (irq)
    );

    assign m_valid = !empty;
    assign m_data  = head_word[DW-1:0];
    assign m_right = head_word[DW];

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STAT: begin
                reg_rdata[BIT_LVL]        = st[0];
                reg_rdata[BIT_UND]        = st[1];
                reg_rdata[BIT_OVF]        = st[2];
                reg_rdata[OCC_LSB +: CW]  = occ;
            end
            SEL_IEN:  reg_rdata[1:0]      = ctl_q.ien;
            SEL_TRIG: reg_rdata[CW-1:0]   = ctl_q.trig;
            default:  reg_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/atf_chk.sv
module atf_chk #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          m_valid,
    input logic          m_ready,
    input logic          irq,
    input logic [CW-1:0] occ,
    input logic [2:0]    st,
    input logic [1:0]    ien
);
    logic data_wr, stat_wr;
    assign data_wr = reg_wr && (reg_addr == 2'd0);
    assign stat_wr = reg_wr && (reg_addr == 2'd1);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R1
    valid_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid == (occ != '0));

    // R3
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && occ != CW'(DEPTH) && m_valid && m_ready) |=> (occ == $past(occ)));

    // R6
    empty_und_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !(stat_wr && reg_wdata[1])) |=> st[1]);

    // R8
    clear_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[0]) |=> !st[0]);

    // R9
    irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(st[1:0] & ien));
endmodule

bind audio_tx_fifo atf_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .irq       (irq),
    .occ       (occ),
    .st        (st),
    .ien       (ien_q)
);

// File: tb/audio_tx_fifo_tb.sv
`timescale 1ns/1ps
module audio_tx_fifo_tb;
    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          m_valid, m_ready, m_right, irq;
    logic [DW-1:0] m_data;

    always #4 clk = ~clk;

    audio_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_right(m_right), .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    logic [DW:0]   mq [$];
    logic          md_lvl, md_und, md_ovf, md_irq, md_phase;
    logic [CW-1:0] md_trig;
    logic [1:0]    md_en;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            check(1'b0, "watchdog", "cycles", cyc, 150000);
            summary();
        end
    end

    function automatic void model_reset();
        mq.delete();
        md_lvl = 0; md_und = 0; md_ovf = 0; md_irq = 0; md_phase = 0;
        md_trig = CW'(DEPTH / 2);
        md_en = 2'b00;
    endfunction

    function automatic logic [CW-1:0] md_occ();
        return CW'(mq.size());
    endfunction

    // Advance the model over one clock edge with the inputs applied before it.
    function automatic void model_edge(input logic w, input logic [1:0] a,
                                       input logic [31:0] d, input logic rdy);
        int   n;
        logic dw, push, ovfe, pop, l_n, u_n, o_n;
        logic [2:0] clr;
        n    = mq.size();
        dw   = w && a == 2'd0;
        push = dw && n != DEPTH;
        ovfe = dw && n == DEPTH;
        pop  = rdy && n != 0;
        clr  = (w && a == 2'd1) ? d[2:0] : 3'b000;
        l_n  = clr[0] ? 1'b0 : (md_lvl | (CW'(n) < md_trig));
        u_n  = clr[1] ? 1'b0 : (md_und | (n == 0));
        o_n  = ovfe | (md_ovf & ~clr[2]);
        if (w && a == 2'd2) md_en = d[1:0];
        if (w && a == 2'd3) md_trig = d[CW-1:0];
        if (pop) void'(mq.pop_front());
        if (push) begin
            mq.push_back({md_phase, d});
            md_phase = ~md_phase;
        end
        md_lvl = l_n; md_und = u_n; md_ovf = o_n;
        md_irq = (l_n & md_en[0]) | (u_n & md_en[1]);
    endfunction

    task automatic compare();
        check(m_valid == (mq.size() != 0), "R1", "m_valid", 32'(m_valid), 32'(mq.size() != 0));
        if (mq.size() != 0) begin
            check(m_data == mq[0][DW-1:0], "R1", "m_data", m_data, mq[0][DW-1:0]);
            check(m_right == mq[0][DW], "R2", "m_right", 32'(m_right), 32'(mq[0][DW]));
        end
        check(irq == md_irq, "R9", "irq", 32'(irq), 32'(md_irq));
        case (reg_addr)
            2'd1: begin
                check(reg_rdata[0] == md_lvl, "R5,R7,R8", "level bit", 32'(reg_rdata[0]), 32'(md_lvl));
                check(reg_rdata[1] == md_und, "R6,R7,R8", "underrun bit", 32'(reg_rdata[1]), 32'(md_und));
                check(reg_rdata[2] == md_ovf, "R4", "overflow bit", 32'(reg_rdata[2]), 32'(md_ovf));
                check(reg_rdata[8 +: CW] == md_occ(), "R3", "occupancy", 32'(reg_rdata[8 +: CW]), 32'(md_occ()));
            end
            2'd2: check(reg_rdata == 32'(md_en), "R10", "enable reg", reg_rdata, 32'(md_en));
            2'd3: check(reg_rdata == 32'(md_trig), "R10", "trigger reg", reg_rdata, 32'(md_trig));
            default: check(reg_rdata == '0, "R10", "data port read", reg_rdata, 0);
        endcase
    endtask

    // Drive at a falling edge, compare, cross the rising edge, update the model.
    task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input logic rdy);
        reg_wr = w; reg_addr = a; reg_wdata = d; m_ready = rdy;
        #1;
        compare();
        @(posedge clk);
        model_edge(w, a, d, rdy);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);
        reg_wr = 0; reg_addr = 2'd1; reg_wdata = '0; m_ready = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11: reset state
        check(!m_valid, "R11", "valid after reset", 32'(m_valid), 0);
        check(!irq, "R11", "irq after reset", 32'(irq), 0);
        check(reg_rdata == '0, "R11", "status after reset", reg_rdata, 0);
        reg_addr = 2'd3; #1;
        check(reg_rdata == 32'(DEPTH / 2), "R10", "trigger reset", reg_rdata, DEPTH / 2);

        repeat (2) step(0, 2'd1, 0, 0);
        step(1, 2'd3, 32'd4, 0);
        step(1, 2'd2, 32'd3, 0);
        for (int i = 0; i < 6; i++) step(1, 2'd0, 32'hA000_0000 + 32'(i), 0);
        step(0, 2'd1, 0, 0);
        // R7: occupancy 6 is above trigger 4, yet level stays set
        check(reg_rdata[0] == 1'b1, "R7", "sticky level", 32'(reg_rdata[0]), 1);
        step(1, 2'd1, 32'd1, 0);
        step(0, 2'd1, 0, 0);
        // R8: cleared and condition gone, stays clear
        check(reg_rdata[0] == 1'b0, "R8", "level after clear", 32'(reg_rdata[0]), 0);
        for (int i = 0; i < 6; i++) step(0, 2'd1, 0, 1);
        step(0, 2'd1, 0, 0);
        step(1, 2'd1, 32'd3, 0);
        #0;
        check(reg_rdata[1:0] == 2'b00 && !irq, "R8", "masked one cycle", 32'({irq, reg_rdata[1:0]}), 0);
        step(0, 2'd1, 0, 0);
        check(reg_rdata[1:0] == 2'b11, "R8", "re-set while empty", 32'(reg_rdata[1:0]), 3);

        // R4: fill past full, then push with a pop while full
        for (int i = 0; i < DEPTH + 2; i++) step(1, 2'd0, $urandom, 0);
        step(0, 2'd1, 0, 0);
        check(reg_rdata[2] == 1'b1, "R4", "overflow set", 32'(reg_rdata[2]), 1);
        step(1, 2'd0, 32'hDEAD_BEEF, 1);
        step(1, 2'd0, 32'hCAFE_F00D, 1);
        step(0, 2'd1, 0, 0);
        // R3: push with pop keeps occupancy at DEPTH-1
        check(reg_rdata[8 +: CW] == CW'(DEPTH - 1), "R3", "occupancy push+pop", 32'(reg_rdata[8 +: CW]), DEPTH - 1);
        step(1, 2'd2, 32'd0, 0);
        step(1, 2'd1, 32'd4, 0);
        step(0, 2'd1, 0, 0);
        check(reg_rdata[2] == 1'b0 && !irq, "R4", "overflow cleared, no irq", 32'({irq, reg_rdata[2]}), 0);

        for (int blk = 0; blk < 8; blk++) begin
            int rdy_pct = $urandom_range(10, 90);
            for (int k = 0; k < 500; k++) begin
                int r = $urandom_range(0, 99);
                logic rdy = ($urandom_range(0, 99) < rdy_pct);
                if (r < 55)      step(1, 2'd0, $urandom, rdy);
                else if (r < 62) step(1, 2'd1, 32'($urandom_range(0, 7)), rdy);
                else if (r < 65) step(1, 2'd2, 32'($urandom_range(0, 3)), rdy);
                else if (r < 67) step(1, 2'd3, 32'($urandom_range(0, 80)), rdy);
                else             step(0, 2'($urandom_range(0, 3)), 0, rdy);
            end
        end
        done = 1'b1;
        summary();
    end
endmodule